// File: doc/BRIEF.md
# Flash Write/Erase Completion Poller

This block works out whether a flash byte program or a sector erase has finished. It reads status from the flash location, using the status bits that the flash returns on its data bus while an internal operation is running. It does not use a ready/busy pin or a status register. A single start pulse loads the target address, the intended byte and the options. The block then drives a simple synchronous read port until it reaches a verdict. Each read has a one-cycle request and a read-valid return.

Two methods are supported:

- **Data polling.** The block compares status bit 7 with the expected value.
- **Toggle.** The block watches bit 6 until two consecutive reads agree.

In both methods, bit 5 is the error indication. When bit 5 is seen, the block makes a mandatory re-read to resolve the race between the error flag and the completion bit. An optional verify read can follow a successful completion. It compares the whole byte with the intended value. A programmable read budget ends the poll with a separate timeout flag.

The result flags hold their value until the next accepted start. The controller issuing the flash command sequence can therefore sample them at any time.

Top module: `flash_done_poller`

## Requirements
- R1: A start pulse while idle is accepted. The block latches the address, intended byte and options, clears all result flags and raises busy. In the next cycle it raises the read request for exactly one cycle, with the read address equal to the latched address.
- R2: In data-polling mode (mode_i = 0), a read whose bit 7 equals the expected bit 7 means completion. The expected bit 7 is bit 7 of the intended byte for a program, and 1 for an erase (erase_i = 1).
- R3: In data-polling mode, a read with bit 7 not matching and bit 5 = 0 causes another read of the same address.
- R4: In data-polling mode, a read with bit 7 not matching and bit 5 = 1 causes exactly one more read. That read gives pass if its bit 7 now matches, and fail otherwise.
- R5: In toggle mode (mode_i = 1), the first read only records bit 6. A later read with bit 5 = 0 whose bit 6 equals the previous read's bit 6 means completion.
- R6: In toggle mode, a read with bit 5 = 1 causes exactly two more reads. The result is pass if their bit 6 values are equal, and fail if they differ.
- R7: With verify_i = 1, completion triggers one extra read. It is compared with the whole expected byte: the intended byte for a program, 8'hFF for an erase. A mismatch gives fail; a match gives pass.
- R8: Each read that is neither a completion nor shows bit 5 = 1 counts against max_reads_i (a value of 0 counts as 1). The read that brings the count to the limit ends the poll with timeout set and pass and fail clear.
- R9: When a poll ends, done_o rises with exactly one of pass_o, fail_o, timeout_o. All four flags stay constant until the next accepted start.
- R10: A start pulse while busy is ignored, together with the address and data present with it.
- R11: A new read request is issued only in the cycle after a read-valid. While a request is outstanding, no further request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mode_i | input | 1 | 0 = data polling on bit 7, 1 = toggle detection on bit 6 |
| erase_i | input | 1 | 1 = sector erase (expected byte 8'hFF), 0 = byte program |
| verify_i | input | 1 | Perform a full-byte verify read after completion |
| addr_i | input | AW | Location to poll |
| data_i | input | 8 | Intended byte for a program |
| max_reads_i | input | CW | Budget of inconclusive status reads (0 means 1) |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data is valid this cycle |
| rd_data_i | input | 8 | Read data |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | Poll finished; result flags valid |
| pass_o | output | 1 | Operation completed successfully |
| fail_o | output | 1 | Error confirmed or verify mismatch |
| timeout_o | output | 1 | Read budget used up without a verdict |

## Verification
The assertions assume the memory side answers every request with exactly one read-valid pulse. That pulse comes no earlier than the cycle after the request and never while the block is idle. They also assume that a start pulse lasts a single cycle. The bench's read responder keeps to these rules: it pulses rd_valid_i once per observed request, after zero to a few waiting cycles, and it raises start_i for one cycle only. Start pulses sent while the block is busy are deliberately placed in the waiting cycles of an outstanding read.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    // Bit positions inside the returned status byte
    localparam int STAT_DONE_BIT = 7;
    localparam int STAT_TOG_BIT  = 6;
    localparam int STAT_ERR_BIT  = 5;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } state_e;

    typedef enum logic [2:0] {
        PH_FIRST,   // toggle mode: first read, only records bit 6
        PH_POLL,    // normal status polling
        PH_RE_A,    // toggle re-test, first of two reads
        PH_RE_B,    // final re-test read (both modes)
        PH_VERIFY   // full-byte verify read
    } phase_e;

    typedef enum logic [1:0] {
        V_AGAIN,
        V_RECHECK,
        V_PASS,
        V_FAIL
    } verdict_e;

endpackage

// File: rtl/fpoll_status_eval.sv
module fpoll_status_eval
    import fpoll_pkg::*;
(
    input  logic       toggle_i,
    input  phase_e     phase_i,
    input  logic [7:0] exp_byte_i,
    input  logic       prev_tog_i,
    input  logic [7:0] rd_byte_i,
    output verdict_e   verdict_o
);

    logic done_match;
    logic tog_same;
    logic err_seen;

    assign done_match = (rd_byte_i[STAT_DONE_BIT] == exp_byte_i[STAT_DONE_BIT]);
    assign tog_same   = (rd_byte_i[STAT_TOG_BIT] == prev_tog_i);
    assign err_seen   = rd_byte_i[STAT_ERR_BIT];

    always_comb begin
        verdict_o = V_AGAIN;
        case (phase_i)
            PH_FIRST: begin
                verdict_o = err_seen ? V_RECHECK : V_AGAIN;
            end
            PH_POLL: begin
                if (!toggle_i) begin
                    if (done_match)    verdict_o = V_PASS;
                    else if (err_seen) verdict_o = V_RECHECK;
                    else               verdict_o = V_AGAIN;
                end else begin
                    if (err_seen)      verdict_o = V_RECHECK;
                    else if (tog_same) verdict_o = V_PASS;
                    else               verdict_o = V_AGAIN;
                end
            end
            PH_RE_A: begin
                verdict_o = V_AGAIN;
            end
            PH_RE_B: begin
                if (toggle_i) verdict_o = tog_same   ? V_PASS : V_FAIL;
                else          verdict_o = done_match ? V_PASS : V_FAIL;
            end
            PH_VERIFY: begin
                verdict_o = (rd_byte_i == exp_byte_i) ? V_PASS : V_FAIL;
            end
            default: verdict_o = V_AGAIN;
        endcase
    end

endmodule

// File: rtl/fpoll_read_budget.sv
module fpoll_read_budget #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    input  logic          bump_i,
    output logic          last_o
);

    localparam int XW = CW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
    } bud_t;

    bud_t bud_d, bud_q;
    logic [XW-1:0] cnt_next;

    assign cnt_next = {1'b0, bud_q.cnt} + XW'(1);
    assign last_o   = (cnt_next >= {1'b0, bud_q.lim});

    always_comb begin
        bud_d = bud_q;
        if (clear_i) begin
            bud_d.cnt = '0;
            bud_d.lim = (limit_i == '0) ? CW'(1) : limit_i;
        end else if (bump_i) begin
            bud_d.cnt = cnt_next[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bud_q.cnt <= '0;
            bud_q.lim <= CW'(1);
        end else begin
            bud_q <= bud_d;
        end
    end

    // R8
    budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bud_q.cnt < bud_q.lim);

    // R8
    budget_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_i && !clear_i) |-> !last_o);

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fpoll_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic          erase_i,
    input  logic          verify_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    data_i,
    input  logic [CW-1:0] max_reads_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_valid_i,
    input  logic [7:0]    rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic          timeout_o
);

    typedef struct packed {
        state_e        state;
        phase_e        phase;
        logic [AW-1:0] addr;
        logic [7:0]    exp_byte;
        logic          toggle;
        logic          verify;
        logic          prev_tog;
        logic          done;
        logic          pass;
        logic          fail;
        logic          tmo;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    verdict_e verdict;
    logic     budget_clear;
    logic     budget_bump;
    logic     budget_last;

    fpoll_status_eval u_eval (
        .toggle_i   (ctl_q.toggle),
        .phase_i    (ctl_q.phase),
        .exp_byte_i (ctl_q.exp_byte),
        .prev_tog_i (ctl_q.prev_tog),
        .rd_byte_i  (rd_data_i),
        .verdict_o  (verdict)
    );

    fpoll_read_budget #(.CW(CW)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (budget_clear),
        .limit_i (max_reads_i),
        .bump_i  (budget_bump),
        .last_o  (budget_last)
    );

    always_comb begin
        ctl_d        = ctl_q;
        budget_clear = 1'b0;
        budget_bump  = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state    = ST_ISSUE;
                    ctl_d.phase    = mode_i ? PH_FIRST : PH_POLL;
                    ctl_d.addr     = addr_i;
                    ctl_d.exp_byte = erase_i ? ERASED_BYTE : data_i;
                    ctl_d.toggle   = mode_i;
                    ctl_d.verify   = verify_i;
                    ctl_d.prev_tog = 1'b0;
                    ctl_d.done     = 1'b0;
                    ctl_d.pass     = 1'b0;
                    ctl_d.fail     = 1'b0;
                    ctl_d.tmo      = 1'b0;
                    budget_clear   = 1'b1;
                end
            end
            ST_ISSUE: begin
                ctl_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_valid_i) begin
                    case (verdict)
                        V_AGAIN: begin
                            ctl_d.prev_tog = rd_data_i[STAT_TOG_BIT];
                            if (ctl_q.phase == PH_RE_A) begin
                                ctl_d.phase = PH_RE_B;
                                ctl_d.state = ST_ISSUE;
                            end else if (budget_last) begin
                                ctl_d.state = ST_IDLE;
                                ctl_d.done  = 1'b1;
                                ctl_d.tmo   = 1'b1;
                            end else begin
                                budget_bump = 1'b1;
                                ctl_d.phase = PH_POLL;
                                ctl_d.state = ST_ISSUE;
                            end
                        end
                        V_RECHECK: begin
                            ctl_d.phase = ctl_q.toggle ? PH_RE_A : PH_RE_B;
                            ctl_d.state = ST_ISSUE;
                        end
                        V_PASS: begin
                            if (ctl_q.verify && ctl_q.phase != PH_VERIFY) begin
                                ctl_d.phase = PH_VERIFY;
                                ctl_d.state = ST_ISSUE;
                            end else begin
                                ctl_d.state = ST_IDLE;
                                ctl_d.done  = 1'b1;
                                ctl_d.pass  = 1'b1;
                            end
                        end
                        V_FAIL: begin
                            ctl_d.state = ST_IDLE;
                            ctl_d.done  = 1'b1;
                            ctl_d.fail  = 1'b1;
                        end
                        default: ctl_d.state = ST_IDLE;
                    endcase
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state    <= ST_IDLE;
            ctl_q.phase    <= PH_POLL;
            ctl_q.addr     <= '0;
            ctl_q.exp_byte <= '0;
            ctl_q.toggle   <= 1'b0;
            ctl_q.verify   <= 1'b0;
            ctl_q.prev_tog <= 1'b0;
            ctl_q.done     <= 1'b0;
            ctl_q.pass     <= 1'b0;
            ctl_q.fail     <= 1'b0;
            ctl_q.tmo      <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_req_o  = (ctl_q.state == ST_ISSUE);
    assign rd_addr_o = ctl_q.addr;
    assign busy_o    = (ctl_q.state != ST_IDLE);
    assign done_o    = ctl_q.done;
    assign pass_o    = ctl_q.pass;
    assign fail_o    = ctl_q.fail;
    assign timeout_o = ctl_q.tmo;

    // R1
    req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    // R1
    first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (rd_req_o && rd_addr_o == $past(addr_i)));

    // R9
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $onehot({pass_o, fail_o, timeout_o}));

    // R9
    no_result_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ({done_o, pass_o, fail_o, timeout_o} == 4'b0000));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable({done_o, pass_o, fail_o, timeout_o}));

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(rd_addr_o));

    // R11
    req_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && $past(busy_o)) |-> $past(rd_valid_i));

endmodule

// File: tb/sim_flash_done_poller.sv
module sim_flash_done_poller;

    localparam int AW = 16;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic          mode_i;
    logic          erase_i;
    logic          verify_i;
    logic [AW-1:0] addr_i;
    logic [7:0]    data_i;
    logic [CW-1:0] max_reads_i;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_valid_i;
    logic [7:0]    rd_data_i;
    logic          busy_o;
    logic          done_o;
    logic          pass_o;
    logic          fail_o;
    logic          timeout_o;

    int compared   = 0;
    int mismatched = 0;
    int case_no    = 0;
    logic [7:0] resp[$];

    always #2.5 clk = ~clk;

    flash_done_poller #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .erase_i(erase_i), .verify_i(verify_i), .addr_i(addr_i), .data_i(data_i),
        .max_reads_i(max_reads_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
        .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o), .timeout_o(timeout_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fetch(input logic [7:0] q[$], input int idx);
        if (q.size() == 0) return 8'h00;
        if (idx >= q.size()) return q[q.size()-1];
        return q[idx];
    endfunction

    // Behavioural reference: result 1 = pass, 2 = fail, 3 = timeout
    function automatic void model(input bit tog, input bit er, input bit ver,
                                  input logic [7:0] d, input int maxr,
                                  input logic [7:0] q[$],
                                  output int nr, output int res);
        logic [7:0] e;
        logic [7:0] b;
        logic [7:0] a;
        logic [7:0] c;
        int i, cnt, lim;
        bit prev, have_prev;
        e = er ? 8'hFF : d;
        lim = (maxr == 0) ? 1 : maxr;
        i = 0; cnt = 0; res = 0; prev = 0; have_prev = 0;
        while (res == 0) begin
            b = fetch(q, i); i++;
            if (!tog && b[7] == e[7]) res = 1;
            else if (b[5]) begin
                if (tog) begin
                    a = fetch(q, i); i++;
                    c = fetch(q, i); i++;
                    res = (a[6] == c[6]) ? 1 : 2;
                end else begin
                    a = fetch(q, i); i++;
                    res = (a[7] == e[7]) ? 1 : 2;
                end
            end else if (tog && have_prev && b[6] == prev) res = 1;
            else begin
                prev = b[6]; have_prev = 1;
                cnt++;
                if (cnt >= lim) res = 3;
            end
        end
        if (res == 1 && ver) begin
            a = fetch(q, i); i++;
            res = (a == e) ? 1 : 2;
        end
        nr = i;
    endfunction

    task automatic run_case(input string req, input bit tog, input bit er,
                            input bit ver, input logic [7:0] d, input int maxr,
                            input int lat, input bit poke_busy);
        int nexp, res, n, idx, guard;
        logic [AW-1:0] a;
        logic [3:0] flags;
        model(tog, er, ver, d, maxr, resp, nexp, res);
        case_no++;
        a = AW'(16'h1000 + case_no * 37);
        @(negedge clk);
        start_i = 1'b1; mode_i = tog; erase_i = er; verify_i = ver;
        addr_i = a; data_i = d; max_reads_i = CW'(maxr);
        @(negedge clk);
        start_i = 1'b0;
        check("R1", "busy after start", busy_o, 1'b1);
        n = 0; idx = 0; guard = 0;
        while (!done_o && guard < 500) begin
            guard++;
            if (rd_req_o) begin
                check("R1", "read address", rd_addr_o, a);
                n++;
                @(negedge clk);
                check("R1", "request is one cycle", rd_req_o, 1'b0);
                if (poke_busy) begin
                    start_i = 1'b1; addr_i = ~a; data_i = ~d;
                end
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    start_i = 1'b0;
                    check("R11", "no request while waiting", rd_req_o, 1'b0);
                end
                start_i = 1'b0;
                rd_valid_i = 1'b1;
                rd_data_i = fetch(resp, idx);
                idx++;
                @(negedge clk);
                rd_valid_i = 1'b0;
                rd_data_i = 8'h00;
            end else begin
                @(negedge clk);
            end
        end
        check(req, "read count", n, nexp);
        check(req, "done", done_o, 1'b1);
        check(req, "pass", pass_o, res == 1);
        check(req, "fail", fail_o, res == 2);
        check("R8", "timeout flag", timeout_o, res == 3);
        check("R9", "idle after done", busy_o, 1'b0);
        flags = {done_o, pass_o, fail_o, timeout_o};
        addr_i = ~a;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R9", "flags held", {done_o, pass_o, fail_o, timeout_o}, flags);
            check("R9", "no stray request", rd_req_o, 1'b0);
        end
    endtask

    initial begin
        rst_n = 1'b0; start_i = 0; mode_i = 0; erase_i = 0; verify_i = 0;
        addr_i = '0; data_i = '0; max_reads_i = '0; rd_valid_i = 0; rd_data_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset busy", busy_o, 1'b0);
        check("R1", "reset request", rd_req_o, 1'b0);
        check("R9", "reset flags", {done_o, pass_o, fail_o, timeout_o}, 4'b0000);

        resp = '{8'hA5};                          run_case("R2", 0, 0, 0, 8'hA5, 8, 1, 0);
        resp = '{8'h80, 8'h88, 8'h80, 8'h3C};     run_case("R3", 0, 0, 0, 8'h3C, 8, 2, 0);
        resp = '{8'h00, 8'h20, 8'h81};            run_case("R4", 0, 0, 0, 8'h81, 8, 1, 0);
        resp = '{8'h20, 8'h20};                   run_case("R4", 0, 0, 0, 8'h81, 8, 0, 0);
        resp = '{8'h00, 8'h00, 8'h80};            run_case("R2", 0, 1, 0, 8'h00, 8, 1, 0);
        resp = '{8'h40, 8'h00, 8'h40, 8'h40};     run_case("R5", 1, 0, 0, 8'h12, 8, 1, 0);
        resp = '{8'h40, 8'h20, 8'h44, 8'h40};     run_case("R6", 1, 0, 0, 8'h12, 8, 1, 0);
        resp = '{8'h00, 8'h60, 8'h40, 8'h00};     run_case("R6", 1, 0, 0, 8'h12, 8, 2, 0);
        resp = '{8'h80};                          run_case("R8", 0, 0, 0, 8'h00, 3, 1, 0);
        resp = '{8'h00};                          run_case("R8", 1, 0, 0, 8'h00, 0, 1, 0);
        resp = '{8'h80, 8'h5A, 8'h5A};            run_case("R7", 0, 0, 1, 8'h5A, 8, 1, 0);
        resp = '{8'h5A, 8'h5B};                   run_case("R7", 0, 0, 1, 8'h5A, 8, 1, 0);
        resp = '{8'h00, 8'hFF, 8'hFF};            run_case("R7", 0, 1, 1, 8'h00, 8, 0, 0);
        resp = '{8'h80, 8'h88, 8'h3C};            run_case("R10", 0, 0, 0, 8'h3C, 8, 2, 1);
        resp = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
                                                  run_case("R11", 1, 0, 0, 8'h00, 4, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL R9 watchdog: actual no completion expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule